// File: doc/BRIEF.md
# Processor Clock, Reset and Ready Generator

This block turns one fast source clock into the timing signals a small processor system needs. A select pin picks the source, either a crystal oscillator or an external frequency input. From that source the block derives a processor clock at one third of the source rate, with the high phase lasting one source period and the low phase two. It also derives a square-wave peripheral clock at one sixth of the source rate. A buffered copy of the selected source is driven out so that other processors in a multiprocessor system can take it as their external frequency input.

The block also conditions two control inputs. An active-low reset request is turned into an active-high processor reset. That reset is resynchronized on rising edges of the processor clock. Two ready channels each have a ready request and an active-low address enable. They are merged into a single READY output, which is captured on falling edges of the processor clock. A select pin sets the capture depth to one or two stages.

All logic runs on the selected source clock. Divider phases drive per-edge enables, so no derived clock feeds a flop. The asynchronous reset `rst_ni` sets the divider to a known phase.

Top module: `cpu_clkgen`

## Requirements
- R1: Counting the first source rising edge after `rst_ni` is released as edge 1, `clk_o` is high after edge k exactly when k is a multiple of 3. It is therefore high for one source period in every three.
- R2: `pclk_o` is high after edge k exactly when k mod 6 is 3, 4 or 5. This gives a 50 percent duty cycle at one sixth of the source rate, and every `pclk_o` edge coincides with a rising edge of `clk_o`.
- R3: `src_sel_i` = 0 selects `xtal_i` and `src_sel_i` = 1 selects `efi_i` as the source. `osc_o` follows the selected source, so the rising edges of `osc_o` are one selected-source period apart.
- R4: `reset_o` equals the inverse of `res_ni` as sampled at the rising edge of `clk_o` two rising edges earlier. It changes only at rising edges of `clk_o`.
- R5: Channel n requests ready when `rdyn_i` is 1 and `aenn_ni` is 0. The combined request is the OR of the two channels.
- R6: The combined request is sampled on each falling edge of `clk_o` (source edges k with k mod 3 = 1). With `async_sel_i` = 1, `ready_o` shows the value from the latest falling edge (one stage). With `async_sel_i` = 0, it shows the value from the falling edge before that (two stages).
- R7: While `rst_ni` is low, `clk_o` = 0, `pclk_o` = 0, `ready_o` = 0 and `reset_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xtal_i | input | 1 | Crystal oscillator source clock |
| efi_i | input | 1 | External frequency source clock |
| src_sel_i | input | 1 | Source select: 0 crystal, 1 external |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| res_ni | input | 1 | Active-low reset request |
| rdy1_i | input | 1 | Ready request, channel 1 |
| aen1_ni | input | 1 | Active-low address enable, channel 1 |
| rdy2_i | input | 1 | Ready request, channel 2 |
| aen2_ni | input | 1 | Active-low address enable, channel 2 |
| async_sel_i | input | 1 | Ready stages: 0 two, 1 one |
| clk_o | output | 1 | Processor clock, source/3, 1:3 duty |
| pclk_o | output | 1 | Peripheral clock, source/6, 50 percent duty |
| osc_o | output | 1 | Buffered copy of the selected source |
| reset_o | output | 1 | Synchronized active-high processor reset |
| ready_o | output | 1 | Synchronized ready |

## Verification
The divider phases are checked on every source edge against the edge index taken modulo 3 and 6. This is done for both sources, whose periods differ (8 ns and 12 ns), and the measured `osc_o` period shows which source was actually picked. All sixteen combinations of the two ready/enable pairs are swept under both synchronizer depths. This separates the AND gating inside a channel from the OR across channels, and a one-stage delay from a two-stage delay. The reset request is held low, released, and then pulsed again, which shows the two-edge delay on both the falling and the rising transition of `reset_o`.

// File: rtl/cpu_clkgen_pkg.sv
package cpu_clkgen_pkg;
  localparam int unsigned PROC_DIV_DEF   = 3;
  localparam int unsigned RST_STAGES_DEF = 2;
  localparam int unsigned RDY_STAGES_DEF = 2;
  localparam int unsigned RDY_CH_DEF     = 2;
endpackage

// File: rtl/cpu_clkgen_div.sv
module cpu_clkgen_div #(
  parameter int unsigned PROC_DIV = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic clk_o,
  output logic pclk_o,
  output logic rise_en_o,
  output logic fall_en_o
);
  localparam int unsigned CNT_MAX = 2 * PROC_DIV;
  localparam int unsigned CW      = $clog2(CNT_MAX);
  localparam logic [CW-1:0] LAST  = CW'(CNT_MAX - 1);
  localparam logic [CW-1:0] DIVV  = CW'(PROC_DIV);

  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          clk_q, pclk_q;

  // one shared phase counter keeps pclk edges on clk rising edges
  always_comb begin
    cnt_nxt = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign rise_en_o = ((cnt_nxt % DIVV) == '0);
  assign fall_en_o = ((cnt_q % DIVV) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      clk_q  <= 1'b0;
      pclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      clk_q  <= rise_en_o;
      pclk_q <= (cnt_nxt >= DIVV);
    end
  end

  assign clk_o  = clk_q;
  assign pclk_o = pclk_q;
endmodule

// File: rtl/cpu_clkgen_sync.sv
module cpu_clkgen_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              d_i,
  output logic [STAGES-1:0] q_o
);
  logic [STAGES-1:0] q_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic d_s;
    if (s == 0) begin : g_first
      assign d_s = d_i;
    end else begin : g_next
      assign d_s = q_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   q_q[s] <= RST_VAL;
      else if (en_i) q_q[s] <= d_s;
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/cpu_clkgen_rdy.sv
module cpu_clkgen_rdy #(
  parameter int unsigned NCH = 2
) (
  input  logic [NCH-1:0] rdy_i,
  input  logic [NCH-1:0] aen_ni,
  output logic           req_o
);
  assign req_o = |(rdy_i & ~aen_ni);
endmodule

// File: rtl/cpu_clkgen.sv
module cpu_clkgen
  import cpu_clkgen_pkg::*;
#(
  parameter int unsigned PROC_DIV   = PROC_DIV_DEF,
  parameter int unsigned RST_STAGES = RST_STAGES_DEF,
  parameter int unsigned RDY_STAGES = RDY_STAGES_DEF
) (
  input  logic xtal_i,
  input  logic efi_i,
  input  logic src_sel_i,
  input  logic rst_ni,
  input  logic res_ni,
  input  logic rdy1_i,
  input  logic aen1_ni,
  input  logic rdy2_i,
  input  logic aen2_ni,
  input  logic async_sel_i,
  output logic clk_o,
  output logic pclk_o,
  output logic osc_o,
  output logic reset_o,
  output logic ready_o
);
  localparam int unsigned NCH = RDY_CH_DEF;

  logic src_clk;
  logic rise_en, fall_en;
  logic rdy_req;
  logic [RST_STAGES-1:0] rst_q;
  logic [RDY_STAGES-1:0] rdy_q;

  // src_sel_i is expected static while rst_ni is high
  assign src_clk = src_sel_i ? efi_i : xtal_i;
  assign osc_o   = src_clk;

  cpu_clkgen_div #(.PROC_DIV(PROC_DIV)) u_div (
    .clk_i     (src_clk),
    .rst_ni    (rst_ni),
    .clk_o     (clk_o),
    .pclk_o    (pclk_o),
    .rise_en_o (rise_en),
    .fall_en_o (fall_en)
  );

  cpu_clkgen_sync #(.STAGES(RST_STAGES), .RST_VAL(1'b1)) u_rst_sync (
    .clk_i  (src_clk),
    .rst_ni (rst_ni),
    .en_i   (rise_en),
    .d_i    (~res_ni),
    .q_o    (rst_q)
  );

  cpu_clkgen_rdy #(.NCH(NCH)) u_rdy (
    .rdy_i  ({rdy2_i, rdy1_i}),
    .aen_ni ({aen2_ni, aen1_ni}),
    .req_o  (rdy_req)
  );

  cpu_clkgen_sync #(.STAGES(RDY_STAGES), .RST_VAL(1'b0)) u_rdy_sync (
    .clk_i  (src_clk),
    .rst_ni (rst_ni),
    .en_i   (fall_en),
    .d_i    (rdy_req),
    .q_o    (rdy_q)
  );

  assign reset_o = rst_q[RST_STAGES-1];
  assign ready_o = async_sel_i ? rdy_q[0] : rdy_q[RDY_STAGES-1];
endmodule

// File: rtl/cpu_clkgen_chk.sv
module cpu_clkgen_chk (
  input logic osc_o,
  input logic rst_ni,
  input logic clk_o,
  input logic pclk_o,
  input logic reset_o,
  input logic ready_o
);
  assert_clk_high_one_R1: assert property (@(posedge osc_o) disable iff (!rst_ni)
    $rose(clk_o) |=> $fell(clk_o)) else $error("clk_o high longer than one source period");

  assert_clk_low_two_R1: assert property (@(posedge osc_o) disable iff (!rst_ni)
    $fell(clk_o) |=> !clk_o) else $error("clk_o low shorter than two source periods");

  assert_pclk_aligned_R2: assert property (@(posedge osc_o) disable iff (!rst_ni)
    !$stable(pclk_o) |-> $rose(clk_o)) else $error("pclk_o edge not on clk_o rise");

  assert_reset_on_rise_R4: assert property (@(posedge osc_o) disable iff (!rst_ni)
    !$stable(reset_o) |-> $rose(clk_o)) else $error("reset_o changed off clk_o rise");

  assert_ready_on_fall_R6: assert property (@(posedge osc_o) disable iff (!rst_ni)
    !$stable(ready_o) |-> $fell(clk_o)) else $error("ready_o changed off clk_o fall");
endmodule

bind cpu_clkgen cpu_clkgen_chk u_chk (.*);

// File: tb/cpu_clkgen_tb.sv
`timescale 1ns/1ps
module cpu_clkgen_tb;
  logic xtal_i = 1'b0;
  logic efi_i  = 1'b0;
  logic src_sel_i, rst_ni, res_ni;
  logic rdy1_i, aen1_ni, rdy2_i, aen2_ni, async_sel_i;
  logic clk_o, pclk_o, osc_o, reset_o, ready_o;

  int nvec = 0;
  int nerr = 0;
  bit done = 1'b0;
  int k;
  logic rh1, rh2, h1, h2;
  realtime last_t;

  always #4 xtal_i = ~xtal_i;
  initial begin
    #3;
    forever #6 efi_i = ~efi_i;
  end

  cpu_clkgen u_dut (
    .xtal_i(xtal_i), .efi_i(efi_i), .src_sel_i(src_sel_i), .rst_ni(rst_ni),
    .res_ni(res_ni), .rdy1_i(rdy1_i), .aen1_ni(aen1_ni), .rdy2_i(rdy2_i),
    .aen2_ni(aen2_ni), .async_sel_i(async_sel_i), .clk_o(clk_o),
    .pclk_o(pclk_o), .osc_o(osc_o), .reset_o(reset_o), .ready_o(ready_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s at edge %0d: actual=%b expected=%b", req, k, act, exp);
    end
  endtask

  task automatic start(input logic sel);
    rst_ni = 1'b0; src_sel_i = sel; res_ni = 1'b0;
    rdy1_i = 1'b0; aen1_ni = 1'b1; rdy2_i = 1'b0; aen2_ni = 1'b1; async_sel_i = 1'b0;
    #20;
    check("R7 clk_o", clk_o, 1'b0);
    check("R7 pclk_o", pclk_o, 1'b0);
    check("R7 ready_o", ready_o, 1'b0);
    check("R7 reset_o", reset_o, 1'b1);
    @(negedge osc_o);
    #1 rst_ni = 1'b1;
    k = 0; rh1 = 1'b1; rh2 = 1'b1; h1 = 1'b0; h2 = 1'b0; last_t = -1.0;
  endtask

  task automatic step();
    realtime t, per;
    logic raw;
    @(posedge osc_o);
    t = $realtime;
    k++;
    raw = (rdy1_i & ~aen1_ni) | (rdy2_i & ~aen2_ni); // R5
    if (k % 3 == 0) begin rh2 = rh1; rh1 = ~res_ni; end
    if (k % 3 == 1) begin h2 = h1; h1 = raw; end
    #2;
    check("R1 clk_o", clk_o, (k % 3 == 0));
    check("R2 pclk_o", pclk_o, (k % 6 >= 3));
    check("R4 reset_o", reset_o, rh2);
    check("R6 ready_o", ready_o, async_sel_i ? h1 : h2);
    per = src_sel_i ? 12.0 : 8.0;
    if (last_t >= 0.0) begin
      check("R3 osc_o period", ((t - last_t) > per - 0.01) && ((t - last_t) < per + 0.01), 1'b1);
    end
    last_t = t;
  endtask

  initial begin
    for (int s = 0; s < 2; s++) begin
      start(logic'(s));
      repeat (6) step();
      res_ni = 1'b1;
      repeat (9) step();
      res_ni = 1'b0;
      repeat (4) step();
      res_ni = 1'b1;
      repeat (8) step();
      for (int a = 0; a < 2; a++) begin
        async_sel_i = logic'(a);
        for (int v = 0; v < 16; v++) begin
          rdy1_i = v[0]; aen1_ni = v[1]; rdy2_i = v[2]; aen2_ni = v[3];
          repeat (6) step();
        end
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      nvec++;
      nerr++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule